// File: doc/BRIEF.md
# Double-Buffered Octal DAC Register Bank

This block is the digital front end of an eight-channel, 13-bit parallel-load converter. A host places a 3-bit channel address and a 13-bit straight-binary word on the bus, then strobes an active-low chip select together with an active-low write line. The word goes into that channel's input register on the rising edge of the write strobe. An active-low, level-sensitive load-all line copies every input register into its DAC register together. If the load-all line is held low, each write reaches its DAC register as soon as it is captured.

All host pins are asynchronous. Two-flop synchronisers bring them into the system clock. A small write state machine runs on the synchronised strobes. Its states are `WS_IDLE` (no strobe), `WS_ARMED` (select and write both low) and `WS_COMMIT` (a one-cycle write pulse). It moves IDLE→ARMED when both strobes are low. It moves ARMED→COMMIT when write rises while select is still low, and ARMED→IDLE when select is released first, which aborts the write. It moves COMMIT→ARMED when both strobes are already low again, otherwise COMMIT→IDLE.

An active-low clear line forces every channel's output select onto the sense-ground path at once. Both register ranks keep their contents. When clear is released, each channel again follows its DAC register.

Top module: `octal_dac_regbank`

## Requirements
- R1: A synchronous reset sets every input register and every DAC register to zero. With clear inactive, every bit of `out_sel_dac` reads 1 after reset.
- R2: A rising edge of `wr_n` while `cs_n` is low stores `din` into the input register picked by `addr`.
- R3: Address value k (000 to 111) selects channel k. Channel k's DAC code appears on `dac_code[13*k+12 : 13*k]`.
- R4: A `wr_n` pulse while `cs_n` is high stores nothing.
- R5: While `ldac_n` is high, the DAC registers hold their values, and newly written input registers do not appear on `dac_code`.
- R6: While `ldac_n` is low, every DAC register takes the value of its input register.
- R7: With `ldac_n` held low, a write reaches the addressed channel's `dac_code` lane without any further strobe. If a write and load-all fall in the same clock, the new word is the one loaded.
- R8: While `clr_n` is low, every bit of `out_sel_dac` is 0, with no clock edge needed.
- R9: Clear changes neither register rank. After `clr_n` returns high, `out_sel_dac` is all ones within three clocks, the DAC codes are unchanged, and a later load-all shows the input registers written before the clear.
- R10: The data word is straight binary with bit 12 as MSB. Codes 0x1FFF, 0x1000 and 0x0000 pass through bit for bit.
- R11: If `cs_n` rises before `wr_n` rises, the write is aborted and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, captures on rising edge |
| ldac_n | input | 1 | Load-all, active low, level sensitive |
| clr_n | input | 1 | Output clear, active low, asynchronous |
| addr | input | 3 | Channel address |
| din | input | 13 | Data word, straight binary |
| dac_code | output | 104 | Eight DAC register codes, channel k in lane k |
| out_sel_dac | output | 8 | Per channel: 1 = DAC path, 0 = sense-ground path |

## Verification
The assertions assume the host strobes last long enough for the synchronisers to see them. They also assume `addr` and `din` stay stable from before `wr_n` rises until several clocks after, and that `cs_n` and `wr_n` never change in the same clock. The stimulus keeps to this by holding each strobe phase for at least three clocks and holding the bus for eight clocks after the write edge. It always releases select several clocks after write rises, except in the deliberate abort case, where select is released well before write rises.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    // Write interface state machine encoding
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_ARMED  = 2'd1,
        WS_COMMIT = 2'd2
    } wstate_e;

    // Index of each control pin inside the synchroniser vector
    localparam int unsigned PIN_CS   = 0;
    localparam int unsigned PIN_WR   = 1;
    localparam int unsigned PIN_LDAC = 2;
    localparam int unsigned PIN_CLR  = 3;
    localparam int unsigned PIN_CNT  = 4;

endpackage

// File: rtl/octdac_sync.sv
module octdac_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RESET_VAL;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/octdac_wr_fsm.sv
module octdac_wr_fsm
    import octdac_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              wr_s,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    wstate_e state, state_nx;
    logic    take;

    // Rising write edge seen while still selected
    assign take = (state == WS_ARMED) && !cs_s && wr_s;

    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE:   if (!cs_s && !wr_s) state_nx = WS_ARMED;
            WS_ARMED: begin
                if (cs_s)       state_nx = WS_IDLE;
                else if (wr_s)  state_nx = WS_COMMIT;
            end
            WS_COMMIT: state_nx = (!cs_s && !wr_s) ? WS_ARMED : WS_IDLE;
            default:   state_nx = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= WS_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (take) begin
            wr_addr <= addr;
            wr_data <= din;
        end
    end

    assign wr_en = (state == WS_COMMIT);

    // R2
    commit_from_armed_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WS_COMMIT) |-> ($past(state) == WS_ARMED));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WS_ARMED && cs_s) |=> (state == WS_IDLE));

endmodule

// File: rtl/octdac_bank.sv
module octdac_bank #(
    parameter int unsigned CHANNELS = 8,
    parameter int unsigned DATA_W   = 13,
    parameter int unsigned ADDR_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         load_all,
    output logic [CHANNELS*DATA_W-1:0]   dac_flat
);

    logic [DATA_W-1:0] in_q  [CHANNELS];
    logic [DATA_W-1:0] in_nx [CHANNELS];
    logic [DATA_W-1:0] dac_q [CHANNELS];

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        logic hit;
        assign hit      = wr_en && (wr_addr == ADDR_W'(i));
        assign in_nx[i] = hit ? wr_data : in_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                in_q[i]  <= '0;
                dac_q[i] <= '0;
            end else begin
                in_q[i] <= in_nx[i];
                if (load_all) dac_q[i] <= in_nx[i];
            end
        end

        assign dac_flat[i*DATA_W +: DATA_W] = dac_q[i];

        // R5
        dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !load_all |=> $stable(dac_q[i]));

        // R6
        dac_copy_chk: assert property (@(posedge clk) disable iff (rst)
            (load_all && !wr_en) |=> (dac_q[i] == $past(in_q[i])));

        // R4
        in_keep_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_addr == ADDR_W'(i)) |=> $stable(in_q[i]));
    end

endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank
    import octdac_pkg::*;
#(
    parameter int unsigned CHANNELS = 8,
    parameter int unsigned DATA_W   = 13,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ADDR_W  = $clog2(CHANNELS),
    localparam int unsigned BUS_W   = CHANNELS * DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                wr_n,
    input  logic                ldac_n,
    input  logic                clr_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   din,
    output logic [BUS_W-1:0]    dac_code,
    output logic [CHANNELS-1:0] out_sel_dac
);

    logic [PIN_CNT-1:0] pins_raw, pins_s;
    logic               wr_en;
    logic [ADDR_W-1:0]  wr_addr;
    logic [DATA_W-1:0]  wr_data;

    assign pins_raw[PIN_CS]   = cs_n;
    assign pins_raw[PIN_WR]   = wr_n;
    assign pins_raw[PIN_LDAC] = ldac_n;
    assign pins_raw[PIN_CLR]  = clr_n;

    octdac_sync #(
        .WIDTH     (PIN_CNT),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ('1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    octdac_wr_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cs_s    (pins_s[PIN_CS]),
        .wr_s    (pins_s[PIN_WR]),
        .addr    (addr),
        .din     (din),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    octdac_bank #(
        .CHANNELS (CHANNELS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load_all (!pins_s[PIN_LDAC]),
        .dac_flat (dac_code)
    );

    // Assertion is immediate through the raw pin; release waits for the
    // synchronised copy so the select never glitches back early.
    assign out_sel_dac = {CHANNELS{clr_n & pins_s[PIN_CLR]}};

    // R8
    clr_force_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (out_sel_dac == '0));

    // R9
    clr_release_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && $past(clr_n) && $past(clr_n, 2)) |-> (&out_sel_dac));

    // R9
    clr_keeps_codes_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && pins_s[PIN_LDAC]) |=> $stable(dac_code));

endmodule

// File: tb/octal_dac_regbank_tb.sv
`timescale 1ns/1ps
module octal_dac_regbank_tb;

    localparam int CH = 8;
    localparam int DW = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
    logic [2:0]    addr = '0;
    logic [DW-1:0] din = '0;
    logic [CH*DW-1:0] dac_code;
    logic [CH-1:0] out_sel_dac;

    always #2.5 clk = ~clk;

    octal_dac_regbank u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ldac_n(ldac_n),
        .clr_n(clr_n), .addr(addr), .din(din),
        .dac_code(dac_code), .out_sel_dac(out_sel_dac)
    );

    typedef struct {
        int            ch;
        logic [DW-1:0] exp;
        string         tag;
    } sb_item_t;

    sb_item_t      sb[$];
    logic [DW-1:0] in_m  [CH];
    logic [DW-1:0] dac_m [CH];
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 0;

    // Monitor: pops expected items and compares away from the clock edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t it;
            logic [DW-1:0] got;
            it  = sb.pop_front();
            got = dac_code[it.ch*DW +: DW];
            n_chk++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s ch%0d dac_code actual=%h expected=%h",
                         it.tag, it.ch, got, it.exp);
            end
        end
    end

    task automatic push_all(input string tag);
        for (int i = 0; i < CH; i++) begin
            sb_item_t it;
            it.ch = i; it.exp = dac_m[i]; it.tag = tag;
            sb.push_back(it);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_sel(input logic [CH-1:0] exp, input string tag);
        n_chk++;
        if (out_sel_dac !== exp) begin
            n_fail++;
            $display("FAIL %s out_sel_dac actual=%b expected=%b", tag, out_sel_dac, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [DW-1:0] d, input bit sel);
        @(negedge clk);
        addr = a; din = d; cs_n = !sel;
        repeat (3) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        if (sel) begin
            in_m[a] = d;
            if (!ldac_n) dac_m[a] = d;
        end
    endtask

    task automatic aborted_write(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; din = d; cs_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        wr_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic load_pulse();
        @(negedge clk);
        ldac_n = 1'b0;
        repeat (4) @(negedge clk);
        ldac_n = 1'b1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < CH; i++) dac_m[i] = in_m[i];
    endtask

    initial begin
        for (int i = 0; i < CH; i++) begin in_m[i] = '0; dac_m[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk_sel('1, "R1");
        push_all("R1");

        // R2 / R5: writes held in input registers while load-all is idle
        host_write(3'd0, 13'h0000, 1'b1);
        host_write(3'd1, 13'h0123, 1'b1);
        host_write(3'd2, 13'h0A5A, 1'b1);
        host_write(3'd3, 13'h1000, 1'b1);
        host_write(3'd4, 13'h0FFF, 1'b1);
        host_write(3'd5, 13'h1555, 1'b1);
        host_write(3'd6, 13'h0AAA, 1'b1);
        host_write(3'd7, 13'h1FFF, 1'b1);
        push_all("R5");
        // R6 / R3 / R10 / R2: load-all copies every channel, lane by address
        load_pulse();
        push_all("R6_R3_R10_R2");

        // R4: write with select high is ignored
        host_write(3'd2, 13'h1234, 1'b0);
        load_pulse();
        push_all("R4");

        // R11: select released before write edge aborts
        aborted_write(3'd5, 13'h0042);
        load_pulse();
        push_all("R11");

        // R7: load-all held low gives write-through
        @(negedge clk);
        ldac_n = 1'b0;
        repeat (4) @(negedge clk);
        host_write(3'd6, 13'h0ABC, 1'b1);
        push_all("R7");
        host_write(3'd0, 13'h1001, 1'b1);
        push_all("R7");
        ldac_n = 1'b1;
        repeat (4) @(negedge clk);

        // Pending input write, then clear
        host_write(3'd1, 13'h1F0F, 1'b1);
        push_all("R5");
        @(negedge clk);
        clr_n = 1'b0;
        #0.5;
        // R8: forced immediately, before any clock edge
        chk_sel('0, "R8");
        repeat (10) @(negedge clk);
        chk_sel('0, "R8");
        push_all("R9");
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
        // R9: release restores the DAC path, codes unchanged
        chk_sel('1, "R9");
        push_all("R9");
        load_pulse();
        push_all("R9");

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule